// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Forms

This block is the integer execute stage of a 32-bit load/store processor pipeline. Each cycle it receives a 6-bit primary opcode, a 6-bit function code, two register operands and a 16-bit immediate. It decodes the operation and computes the result in combinational logic. On the next rising clock edge it captures the result, a signed-overflow flag and an illegal-instruction flag.

Primary opcode 0 selects the register-register group, and the function code then names the operation. Any other primary opcode names a register-immediate operation, and the immediate takes the place of the second register operand. Addition, subtraction and the compares sign-extend the immediate. The bitwise operations zero-extend it. The block raises the overflow flag and leaves handling of it to the logic downstream.

Top module: `int_exec_stage`

## Requirements
- R1: When `rst_n` is low at a rising edge, `result_q`, `ovf_q` and `illegal_q` are all 0 after that edge.
- R2: Outputs are registered. Inputs present at a rising edge appear on the outputs after that edge and stay there until the next edge.
- R3: With opcode 0, function 0x04 gives src_a + src_b and function 0x06 gives src_a - src_b. Opcode 0x14 gives src_a + sext(imm) and opcode 0x16 gives src_a - sext(imm). Results wrap modulo 2^32.
- R4: `ovf_q` is 1 only for the four operations of R3, and only when the exact signed result does not fit in 32 bits. Every other operation leaves it 0.
- R5: With opcode 0, functions 0x08, 0x09 and 0x0A give AND, OR and XOR of src_a and src_b. Opcodes 0x18, 0x19 and 0x1A give the same operations with the zero-extended immediate.
- R6: With opcode 0, functions 0x0C, 0x0E and 0x0F give logical left, logical right and arithmetic right shifts of src_a by src_b[4:0]. Opcodes 0x1C, 0x1E and 0x1F shift by imm[4:0]. The arithmetic shift fills with the sign bit of src_a, and the other two fill with 0.
- R7: Opcode 0x1B gives {imm, 16'h0000}. Neither source operand has any effect on it.
- R8: With opcode 0, functions 0x10, 0x12, 0x14, 0x16, 0x18 and 0x1A are the signed compares equal, not-equal, less, less-or-equal, greater and greater-or-equal of src_a against src_b. Opcodes 0x20, 0x22, 0x24, 0x26, 0x28 and 0x2A do the same against sext(imm). The result is 32'h1 when the condition holds and 32'h0 when it does not.
- R9: An opcode not listed in R3 to R8, or a nonzero function code under opcode 0 not listed there, gives result 0, `illegal_q` 1 and `ovf_q` 0.
- R10: Opcode 0 with function 0 is a no-op. It gives result 0 with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 6 | Primary opcode; 0 selects the register-register group |
| fn_code | input | 6 | Function code, used only when op_code is 0 |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| result_q | output | 32 | Registered result |
| ovf_q | output | 1 | Registered signed-overflow flag |
| illegal_q | output | 1 | Registered illegal-instruction flag |

## Verification
Uniform random operands almost never land on the exact signed overflow boundary. Such operands also seldom produce compares that are equal or that sit on a sign change. The stimulus therefore draws each operand from a pool weighted toward 0, 1, all ones, the largest positive value and the most negative value, and mixes in fully random values. Directed cases add sums one step either side of overflow for both add and subtract, in both the register and immediate forms.

Unmapped codes come from drawing the opcode or function code at random from the whole 6-bit space part of the time. Reset is asserted on a cycle whose inputs would otherwise give a nonzero result.

// File: rtl/exu_pkg.sv
// Package: shared codes and types for the integer execute stage.
// Assumes a 6-bit primary opcode and a 6-bit function code.
package exu_pkg;

    localparam int OPC_W = 6;

    // Register-group function codes
    localparam logic [5:0] FN_NOP  = 6'h00;
    localparam logic [5:0] FN_ADD  = 6'h04;
    localparam logic [5:0] FN_SUB  = 6'h06;
    localparam logic [5:0] FN_AND  = 6'h08;
    localparam logic [5:0] FN_OR   = 6'h09;
    localparam logic [5:0] FN_XOR  = 6'h0A;
    localparam logic [5:0] FN_SLL  = 6'h0C;
    localparam logic [5:0] FN_SRL  = 6'h0E;
    localparam logic [5:0] FN_SRA  = 6'h0F;
    localparam logic [5:0] FN_SEQ  = 6'h10;
    localparam logic [5:0] FN_SNE  = 6'h12;
    localparam logic [5:0] FN_SLT  = 6'h14;
    localparam logic [5:0] FN_SLE  = 6'h16;
    localparam logic [5:0] FN_SGT  = 6'h18;
    localparam logic [5:0] FN_SGE  = 6'h1A;

    // Primary opcodes
    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_ADDI = 6'h14;
    localparam logic [5:0] OPC_SUBI = 6'h16;
    localparam logic [5:0] OPC_ANDI = 6'h18;
    localparam logic [5:0] OPC_ORI  = 6'h19;
    localparam logic [5:0] OPC_XORI = 6'h1A;
    localparam logic [5:0] OPC_LHI  = 6'h1B;
    localparam logic [5:0] OPC_SLLI = 6'h1C;
    localparam logic [5:0] OPC_SRLI = 6'h1E;
    localparam logic [5:0] OPC_SRAI = 6'h1F;
    localparam logic [5:0] OPC_SEQI = 6'h20;
    localparam logic [5:0] OPC_SNEI = 6'h22;
    localparam logic [5:0] OPC_SLTI = 6'h24;
    localparam logic [5:0] OPC_SLEI = 6'h26;
    localparam logic [5:0] OPC_SGTI = 6'h28;
    localparam logic [5:0] OPC_SGEI = 6'h2A;

    // Internal operation selector
    typedef enum logic [4:0] {
        XOP_NOP, XOP_ADD, XOP_SUB, XOP_AND, XOP_OR, XOP_XOR,
        XOP_SLL, XOP_SRL, XOP_SRA, XOP_LHI,
        XOP_CEQ, XOP_CNE, XOP_CLT, XOP_CLE, XOP_CGT, XOP_CGE,
        XOP_BAD
    } xop_e;

    // Decoded control bundle
    typedef struct packed {
        xop_e op;
        logic use_imm;
        logic imm_zext;
        logic illegal;
    } exu_ctl_t;

endpackage

// File: rtl/exu_decode.sv
// Module: exu_decode
// Turns the primary opcode and function code into one operation selector.
// It also chooses the operand source and the immediate extension.
// Assumes opcode 0 is the register group. Anything not in the map is flagged illegal.
module exu_decode
    import exu_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    input  logic [OPC_W-1:0] fn_code,
    output exu_ctl_t         ctl
);

    // Decode the register group from the function code, the rest from the opcode
    always_comb begin
        ctl = '{op: XOP_NOP, use_imm: 1'b0, imm_zext: 1'b0, illegal: 1'b0};
        if (op_code == OPC_REG) begin
            unique case (fn_code)
                FN_NOP: ctl.op = XOP_NOP;
                FN_ADD: ctl.op = XOP_ADD;
                FN_SUB: ctl.op = XOP_SUB;
                FN_AND: ctl.op = XOP_AND;
                FN_OR:  ctl.op = XOP_OR;
                FN_XOR: ctl.op = XOP_XOR;
                FN_SLL: ctl.op = XOP_SLL;
                FN_SRL: ctl.op = XOP_SRL;
                FN_SRA: ctl.op = XOP_SRA;
                FN_SEQ: ctl.op = XOP_CEQ;
                FN_SNE: ctl.op = XOP_CNE;
                FN_SLT: ctl.op = XOP_CLT;
                FN_SLE: ctl.op = XOP_CLE;
                FN_SGT: ctl.op = XOP_CGT;
                FN_SGE: ctl.op = XOP_CGE;
                default: begin
                    ctl.op      = XOP_BAD;
                    ctl.illegal = 1'b1;
                end
            endcase
        end else begin
            ctl.use_imm = 1'b1;
            unique case (op_code)
                OPC_ADDI: ctl.op = XOP_ADD;
                OPC_SUBI: ctl.op = XOP_SUB;
                OPC_ANDI: begin ctl.op = XOP_AND; ctl.imm_zext = 1'b1; end
                OPC_ORI:  begin ctl.op = XOP_OR;  ctl.imm_zext = 1'b1; end
                OPC_XORI: begin ctl.op = XOP_XOR; ctl.imm_zext = 1'b1; end
                OPC_LHI:  ctl.op = XOP_LHI;
                OPC_SLLI: ctl.op = XOP_SLL;
                OPC_SRLI: ctl.op = XOP_SRL;
                OPC_SRAI: ctl.op = XOP_SRA;
                OPC_SEQI: ctl.op = XOP_CEQ;
                OPC_SNEI: ctl.op = XOP_CNE;
                OPC_SLTI: ctl.op = XOP_CLT;
                OPC_SLEI: ctl.op = XOP_CLE;
                OPC_SGTI: ctl.op = XOP_CGT;
                OPC_SGEI: ctl.op = XOP_CGE;
                default: begin
                    ctl.op      = XOP_BAD;
                    ctl.illegal = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/exu_addsub.sv
// Module: exu_addsub
// Adder and subtractor with a signed-overflow output, plus signed compare flags.
// Assumes two's-complement operands of DATA_W bits.
module exu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf,
    output logic              lt,
    output logic              eq
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opb_inv;
    logic [DATA_W:0]   diff_x;

    // Shared adder: subtraction adds the inverted operand plus one
    always_comb begin
        opb_inv = do_sub ? ~opb : opb;
        sum     = opa + opb_inv + {{(DATA_W-1){1'b0}}, do_sub};
        ovf     = (opa[MSB] == opb_inv[MSB]) && (sum[MSB] != opa[MSB]);
    end

    // Compare path: one extra bit makes the sign of the difference exact
    always_comb begin
        diff_x = {opa[MSB], opa} - {opb[MSB], opb};
        lt     = diff_x[DATA_W];
        eq     = (opa == opb);
    end

endmodule

// File: rtl/exu_shifter.sv
// Module: exu_shifter
// Log-stage barrel shifter giving left-logical, right-logical and right-arithmetic results.
// Assumes DATA_W is a power of two. The shift amount is its low log2(DATA_W) bits.
module exu_shifter #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    input  logic              arith,
    output logic [DATA_W-1:0] shl,
    output logic [DATA_W-1:0] shr
);

    logic [DATA_W-1:0] lst [0:SH_W];
    logic [DATA_W-1:0] rst_s [0:SH_W];
    logic              fill;

    assign fill     = arith & din[DATA_W-1];
    assign lst[0]   = din;
    assign rst_s[0] = din;

    // One stage per amount bit; stage k moves the data by 2**k places
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int S = 1 << k;
        assign lst[k+1]   = amt[k] ? {lst[k][DATA_W-1-S:0], {S{1'b0}}} : lst[k];
        assign rst_s[k+1] = amt[k] ? {{S{fill}}, rst_s[k][DATA_W-1:S]} : rst_s[k];
    end

    assign shl = lst[SH_W];
    assign shr = rst_s[SH_W];

endmodule

// File: rtl/int_exec_stage.sv
// Module: int_exec_stage (top)
// Integer execute stage: decode, select the operand, compute, then register the result and flags.
// Assumes a synchronous active-low reset and one-cycle latency from inputs to outputs.
module int_exec_stage
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        op_code,
    input  logic [5:0]        fn_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result_q,
    output logic              ovf_q,
    output logic              illegal_q
);

    localparam int SH_W  = $clog2(DATA_W);
    localparam int EXT_W = DATA_W - IMM_W;

    exu_ctl_t          ctl;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] sum;
    logic              add_ovf;
    logic              lt;
    logic              eq;
    logic [DATA_W-1:0] shl;
    logic [DATA_W-1:0] shr;
    logic [DATA_W-1:0] res_d;
    logic              ovf_d;
    logic              cmp_hit;

    exu_decode u_decode (
        .op_code (op_code),
        .fn_code (fn_code),
        .ctl     (ctl)
    );

    // Extend the immediate and pick the second operand
    always_comb begin
        imm_ext = ctl.imm_zext ? {{EXT_W{1'b0}}, imm} : {{EXT_W{imm[IMM_W-1]}}, imm};
        opb     = ctl.use_imm ? imm_ext : src_b;
    end

    exu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .opa    (src_a),
        .opb    (opb),
        .do_sub (ctl.op == XOP_SUB),
        .sum    (sum),
        .ovf    (add_ovf),
        .lt     (lt),
        .eq     (eq)
    );

    exu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shifter (
        .din   (src_a),
        .amt   (opb[SH_W-1:0]),
        .arith (ctl.op == XOP_SRA),
        .shl   (shl),
        .shr   (shr)
    );

    // Evaluate the compare condition named by the operation
    always_comb begin
        unique case (ctl.op)
            XOP_CEQ: cmp_hit = eq;
            XOP_CNE: cmp_hit = !eq;
            XOP_CLT: cmp_hit = lt;
            XOP_CLE: cmp_hit = lt | eq;
            XOP_CGT: cmp_hit = !(lt | eq);
            XOP_CGE: cmp_hit = !lt;
            default: cmp_hit = 1'b0;
        endcase
    end

    // Select the result and gate the overflow flag to the add and subtract operations
    always_comb begin
        ovf_d = 1'b0;
        unique case (ctl.op)
            XOP_ADD, XOP_SUB: begin
                res_d = sum;
                ovf_d = add_ovf;
            end
            XOP_AND: res_d = src_a & opb;
            XOP_OR:  res_d = src_a | opb;
            XOP_XOR: res_d = src_a ^ opb;
            XOP_SLL: res_d = shl;
            XOP_SRL, XOP_SRA: res_d = shr;
            XOP_LHI: res_d = {imm, {EXT_W{1'b0}}};
            XOP_CEQ, XOP_CNE, XOP_CLT, XOP_CLE, XOP_CGT, XOP_CGE:
                res_d = {{(DATA_W-1){1'b0}}, cmp_hit};
            default: res_d = '0;
        endcase
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q  <= '0;
            ovf_q     <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            result_q  <= res_d;
            ovf_q     <= ovf_d;
            illegal_q <= ctl.illegal;
        end
    end

endmodule

// File: rtl/exu_checker.sv
// Module: exu_checker
// Protocol checks on the ports of int_exec_stage, attached with bind.
// Assumes the opcode map in exu_pkg and one-cycle output latency.
module exu_checker
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        op_code,
    input logic [5:0]        fn_code,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm,
    input logic [DATA_W-1:0] result_q,
    input logic              ovf_q,
    input logic              illegal_q
);

    logic is_addsub;
    logic is_cmp;

    // Classify the incoming codes independently of the decoder
    always_comb begin
        is_addsub = (op_code == OPC_ADDI) || (op_code == OPC_SUBI) ||
                    ((op_code == OPC_REG) && ((fn_code == FN_ADD) || (fn_code == FN_SUB)));
        is_cmp    = (op_code inside {OPC_SEQI, OPC_SNEI, OPC_SLTI, OPC_SLEI, OPC_SGTI, OPC_SGEI}) ||
                    ((op_code == OPC_REG) &&
                     (fn_code inside {FN_SEQ, FN_SNE, FN_SLT, FN_SLE, FN_SGT, FN_SGE}));
    end

    // R1: a reset cycle leaves all outputs cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result_q == '0 && !ovf_q && !illegal_q));

    // R4: overflow only follows add or subtract
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_addsub |=> !ovf_q);

    // R7: load-high ignores the sources
    p_lhi_place_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_LHI) |=> (result_q == {$past(imm), {(DATA_W-IMM_W){1'b0}}}));

    // R8: compares yield only 0 or 1
    p_cmp_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> (result_q[DATA_W-1:1] == '0));

    // R9: an illegal code carries a zero result and no overflow
    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> (result_q == '0 && !ovf_q));

    // R10: the all-zero code is a clean no-op
    p_nop_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_REG && fn_code == FN_NOP) |=> (result_q == '0 && !ovf_q && !illegal_q));

endmodule

bind int_exec_stage exu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (.*);

// File: tb/int_exec_stage_tb_top.sv
// Bench: seeded random plus directed cases, checked against a model written from the requirements.
module int_exec_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_code = '0;
    logic [5:0]  fn_code = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [31:0] result_q;
    logic        ovf_q;
    logic        illegal_q;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    int_exec_stage dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .fn_code(fn_code),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .result_q(result_q), .ovf_q(ovf_q), .illegal_q(illegal_q)
    );

    // Expected {illegal, overflow, result}
    function automatic logic [33:0] model(input logic [5:0] op, input logic [5:0] fn,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [15:0] im);
        logic [31:0] se, ze, y, r;
        logic signed [32:0] wide;
        logic ov, bad;
        int   code;
        se = {{16{im[15]}}, im};
        ze = {16'h0, im};
        ov = 1'b0; bad = 1'b0; r = '0;
        // Map both forms onto one code: register uses fn, immediate uses op - 0x10
        if (op == 6'h00) begin code = fn; y = b; end
        else begin
            code = int'(op) - 16;
            y = (op inside {6'h18, 6'h19, 6'h1A}) ? ze : se;
            if (!(op inside {6'h14,6'h16,6'h18,6'h19,6'h1A,6'h1B,6'h1C,6'h1E,6'h1F,
                             6'h20,6'h22,6'h24,6'h26,6'h28,6'h2A})) code = -1;
            if (op == 6'h1B) code = 100;
            if (op >= 6'h20) code = int'(op) - 16;
        end
        if (op != 6'h00 && op >= 6'h14 && op <= 6'h1F && op != 6'h1B && code >= 0)
            code = int'(op) - 16;
        case (code)
            0:  r = '0;
            4:  begin wide = $signed({a[31],a}) + $signed({y[31],y}); r = wide[31:0];
                      ov = (wide > 33'sd2147483647) || (wide < -33'sd2147483648); end
            6:  begin wide = $signed({a[31],a}) - $signed({y[31],y}); r = wide[31:0];
                      ov = (wide > 33'sd2147483647) || (wide < -33'sd2147483648); end
            8:  r = a & y;
            9:  r = a | y;
            10: r = a ^ y;
            12: r = a << y[4:0];
            14: r = a >> y[4:0];
            15: r = $unsigned($signed(a) >>> y[4:0]);
            16: r = {31'h0, a == y};
            18: r = {31'h0, a != y};
            20: r = {31'h0, $signed(a) <  $signed(y)};
            22: r = {31'h0, $signed(a) <= $signed(y)};
            24: r = {31'h0, $signed(a) >  $signed(y)};
            26: r = {31'h0, $signed(a) >= $signed(y)};
            100: r = {im, 16'h0};
            default: bad = 1'b1;
        endcase
        if (op == 6'h00 && code == 0) bad = 1'b0;
        if (bad) begin r = '0; ov = 1'b0; end
        return {bad, ov, r};
    endfunction

    function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
        int c;
        c = (op == 0) ? int'(fn) : int'(op) - 16;
        if (op == 6'h1B) return "R7";
        if (op == 0 && fn == 0) return "R10";
        if (c == 4 || c == 6) return "R3/R4";
        if (c >= 8 && c <= 10) return "R5";
        if (c == 12 || c == 14 || c == 15) return "R6";
        if (c >= 16 && c <= 26 && c % 2 == 0) return "R8";
        return "R9";
    endfunction

    // Drive one operation at a falling edge, check it at the next falling edge (R2)
    task automatic run_op(input logic [5:0] op, input logic [5:0] fn, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] im);
        logic [33:0] exp;
        string t;
        @(negedge clk);
        op_code = op; fn_code = fn; src_a = a; src_b = b; imm = im;
        exp = model(op, fn, a, b, im);
        t = tag_of(op, fn);
        @(negedge clk);
        n_tests++;
        if ({illegal_q, ovf_q, result_q} !== exp) begin
            n_fail++;
            $display("FAIL %s R2 op=%h fn=%h a=%h b=%h imm=%h: got ill=%b ovf=%b res=%h, exp ill=%b ovf=%b res=%h",
                     t, op, fn, a, b, im, illegal_q, ovf_q, result_q, exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic check_cleared(input string t);
        n_tests++;
        if (result_q !== 32'h0 || ovf_q !== 1'b0 || illegal_q !== 1'b0) begin
            n_fail++;
            $display("FAIL %s reset: got res=%h ovf=%b ill=%b, exp res=0 ovf=0 ill=0",
                     t, result_q, ovf_q, illegal_q);
        end
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 8)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h0;
            3: return 32'hFFFF_FFFF;
            4: return 32'h1;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [15:0] pick_imm();
        case ($urandom % 6)
            0: return 16'h7FFF;
            1: return 16'h8000;
            2: return 16'hFFFF;
            3: return 16'h0001;
            default: return 16'($urandom);
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] fn_list [15] = '{6'h00,6'h04,6'h06,6'h08,6'h09,6'h0A,6'h0C,6'h0E,6'h0F,
                                     6'h10,6'h12,6'h14,6'h16,6'h18,6'h1A};
        logic [5:0] op_list [15] = '{6'h14,6'h16,6'h18,6'h19,6'h1A,6'h1B,6'h1C,6'h1E,6'h1F,
                                     6'h20,6'h22,6'h24,6'h26,6'h28,6'h2A};
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (2) @(negedge clk);
        check_cleared("R1");
        @(negedge clk); rst_n = 1'b1;

        // Directed: overflow boundaries, R3 and R4
        run_op(6'h00, 6'h04, 32'h7FFF_FFFF, 32'h1, 16'h0);          // overflow
        run_op(6'h00, 6'h04, 32'h7FFF_FFFE, 32'h1, 16'h0);          // just fits
        run_op(6'h00, 6'h06, 32'h8000_0000, 32'h1, 16'h0);          // overflow
        run_op(6'h00, 6'h06, 32'h8000_0001, 32'h1, 16'h0);          // just fits
        run_op(6'h14, 6'h00, 32'h7FFF_FFFF, 32'h0, 16'h0001);       // imm overflow
        run_op(6'h16, 6'h00, 32'h7FFF_FFFF, 32'h0, 16'hFFFF);       // minus -1 overflows
        run_op(6'h14, 6'h00, 32'h0000_0010, 32'h0, 16'hFFF0);       // sign-extended imm
        // R5: zero extension of the immediate
        run_op(6'h19, 6'h00, 32'h0, 32'h0, 16'h8000);
        run_op(6'h18, 6'h00, 32'hFFFF_FFFF, 32'h0, 16'hF0F0);
        // R6: shift amount uses low 5 bits, arithmetic fill
        run_op(6'h00, 6'h0F, 32'h8000_0000, 32'h0000_003F, 16'h0);
        run_op(6'h00, 6'h0E, 32'h8000_0000, 32'h0000_0021, 16'h0);
        run_op(6'h1C, 6'h00, 32'h0000_0001, 32'h0, 16'hFFFF);
        // R7: sources have no effect
        run_op(6'h1B, 6'h00, 32'hDEAD_BEEF, 32'h1234_5678, 16'hA5C3);
        // R8: signed compares on the sign boundary
        run_op(6'h00, 6'h14, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0);
        run_op(6'h24, 6'h00, 32'hFFFF_FFFF, 32'h0, 16'h0000);
        run_op(6'h2A, 6'h00, 32'hFFFF_FFFF, 32'h0, 16'hFFFF);
        // R9: illegal codes
        run_op(6'h00, 6'h05, 32'h7FFF_FFFF, 32'h1, 16'h0);
        run_op(6'h3F, 6'h00, 32'h1, 32'h1, 16'h1);
        // R10: no-op
        run_op(6'h00, 6'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op, fn;
            case ($urandom % 10)
                0: begin op = 6'h00; fn = 6'($urandom); end
                1: begin op = 6'($urandom); fn = 6'($urandom); end
                2, 3, 4, 5: begin op = 6'h00; fn = fn_list[$urandom % 15]; end
                default: begin op = op_list[$urandom % 15]; fn = 6'($urandom); end
            endcase
            run_op(op, fn, pick_val(), pick_val(), pick_imm());
        end

        // R1: reset taken on a cycle whose inputs give a nonzero result
        @(negedge clk);
        op_code = 6'h1B; imm = 16'hFFFF; rst_n = 1'b0;
        @(negedge clk);
        check_cleared("R1");
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule